// File: doc/BRIEF.md
# Configurable Crosspoint I/O Cell

This block is one programmable I/O cell of a digital crosspoint switch. A 4:1 data multiplexer picks one of four routed inputs. The two select bits of that multiplexer come from a bank of shared select lines, and configuration decides which line drives each bit. One storage element, either a transparent latch or an edge-triggered register, can sit in the output path (multiplexer to pad) or in the input path (pad to internal routing). It can also be skipped entirely, so that the output is purely combinational.

The storage element is clocked by a cell clock chosen from a dedicated clock pin or from a pin of a shared clock/enable I/O set. Its clock enable comes from that shared set or from a global enable input. The clock, the enable and the pad output each have their own polarity bit. All configuration arrives as static input ports, which stand in for fuses.

The cell runs on a system clock `clk`. The selected cell clock and enable are sampled on that clock. A register capture is the system-clock edge at which the polarity-adjusted cell clock is first seen high. Both outputs are registered and change on the system-clock edge at which their inputs are sampled.

Top module: `xpt_io_cell`

## Requirements
- R1: When `rst` is sampled high, the stored value, `pad_out` and `route_out` are all 0 after that edge, whatever the configuration.
- R2: The select code {s1,s0} maps to the multiplexer inputs as follows: 00 selects `m_in[0]`, 01 selects `m_in[1]`, 10 selects `m_in[2]` and 11 selects `m_in[3]`. With `cfg_bypass`=1, `pad_out` equals the selected input XOR `cfg_out_inv`, one `clk` edge after the inputs are sampled.
- R3: The select bits are s1 = `sel_lines[cfg_s1_idx]` and s0 = `sel_lines[cfg_s0_idx]`, so remapping the indices changes the selection while `sel_lines` stays fixed.
- R4: When `cfg_out_inv`=1, `pad_out` is the complement of its non-inverted value. `route_out` is never inverted.
- R5: In register mode (`cfg_latch`=0), the element loads its data input only at an edge where the gate is high and was low at the previous edge, and the enable is 1. At every other edge it holds. The gate is the chosen clock pin XOR `cfg_clk_inv`. The enable is the chosen enable pin XOR `cfg_en_inv`.
- R6: The clock source is `dclk_pins[cfg_clk_idx]` when `cfg_clk_ded`=1, and otherwise `shio_pins[cfg_clk_idx]`. The enable source is `gclken[cfg_en_idx]` when `cfg_en_glb`=1, and otherwise `shio_pins[cfg_en_idx]`. An index at or beyond the pin count of the chosen set reads as constant 0.
- R7: In latch mode (`cfg_latch`=1), the element follows its data input at every edge where the gate is 1 and holds while the gate is 0. The enable has no effect in this mode.
- R8: In output-path mode (`cfg_path`=0, `cfg_bypass`=0), the data input is the multiplexer result, `pad_out` is the stored value XOR `cfg_out_inv`, and `route_out` is `pad_in`.
- R9: In input-path mode (`cfg_path`=1, `cfg_bypass`=0), the data input is `pad_in`, `route_out` is the stored value, and `pad_out` is the multiplexer result XOR `cfg_out_inv`.
- R10: With `cfg_bypass`=1, the element is skipped on both paths: `route_out` follows `pad_in` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| m_in | input | 4 | Multiplexer data inputs from routing |
| sel_lines | input | N_SEL | Shared select lines |
| pad_in | input | 1 | Value read from the pad |
| dclk_pins | input | N_DCLK | Dedicated clock pins |
| shio_pins | input | N_SHIO | Shared clock/enable I/O pins |
| gclken | input | N_GEN | Global clock enables |
| cfg_s1_idx | input | SIW | Select line driving s1 |
| cfg_s0_idx | input | SIW | Select line driving s0 |
| cfg_path | input | 1 | 0 output path, 1 input path |
| cfg_latch | input | 1 | 1 latch, 0 register |
| cfg_bypass | input | 1 | 1 skips the storage element |
| cfg_clk_ded | input | 1 | 1 dedicated clock pin, 0 shared set |
| cfg_clk_idx | input | CIW | Clock pin index |
| cfg_clk_inv | input | 1 | Clock polarity invert |
| cfg_en_glb | input | 1 | 1 global enable, 0 shared set |
| cfg_en_idx | input | CIW | Enable pin index |
| cfg_en_inv | input | 1 | Enable polarity invert |
| cfg_out_inv | input | 1 | Pad output polarity invert |
| pad_out | output | 1 | Registered value toward the pad |
| route_out | output | 1 | Registered value toward internal routing |

## Verification
The bench builds the cell with its defaults: four select lines, two dedicated clocks, four shared pins and two global enables. Four select lines allow both index fields to be moved to different lines, so the remapping of the select bits can be shown. Because there are only two dedicated clocks while the index field reaches 3, an out-of-range clock index that must read as constant 0 can be driven. The four shared pins let a non-zero shared index carry an inverted clock, and the two global enables, together with the enable polarity bit, show that the enable gates a register but not a latch.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  typedef enum logic {
    PATH_OUT = 1'b0,
    PATH_IN  = 1'b1
  } path_e;
endpackage

// File: rtl/xpt_sel_mux.sv
module xpt_sel_mux #(
  parameter int N_SEL = 4,
  parameter int SIW   = 2
) (
  input  logic [N_SEL-1:0] sel_lines,
  input  logic [SIW-1:0]   s1_idx,
  input  logic [SIW-1:0]   s0_idx,
  input  logic [3:0]       m_in,
  output logic [1:0]       code,
  output logic             y
);
  logic s1, s0;

  always_comb begin
    s1 = 1'b0;
    s0 = 1'b0;
    for (int i = 0; i < N_SEL; i++) begin
      if (s1_idx == SIW'(i)) s1 = sel_lines[i];
      if (s0_idx == SIW'(i)) s0 = sel_lines[i];
    end
  end

  assign code = {s1, s0};

  always_comb begin
    unique case (code)
      2'b00:   y = m_in[0];
      2'b01:   y = m_in[1];
      2'b10:   y = m_in[2];
      default: y = m_in[3];
    endcase
  end
endmodule

// File: rtl/xpt_ctl_src.sv
module xpt_ctl_src #(
  parameter int N_DCLK = 2,
  parameter int N_SHIO = 4,
  parameter int N_GEN  = 2,
  parameter int CIW    = 2
) (
  input  logic [N_DCLK-1:0] dclk_pins,
  input  logic [N_SHIO-1:0] shio_pins,
  input  logic [N_GEN-1:0]  gclken,
  input  logic              clk_ded,
  input  logic [CIW-1:0]    clk_idx,
  input  logic              clk_inv,
  input  logic              en_glb,
  input  logic [CIW-1:0]    en_idx,
  input  logic              en_inv,
  output logic              gate,
  output logic              en
);
  logic ded_v, shc_v, glb_v, she_v;

  always_comb begin
    ded_v = 1'b0;
    shc_v = 1'b0;
    glb_v = 1'b0;
    she_v = 1'b0;
    for (int i = 0; i < N_DCLK; i++)
      if (clk_idx == CIW'(i)) ded_v = dclk_pins[i];
    for (int i = 0; i < N_SHIO; i++) begin
      if (clk_idx == CIW'(i)) shc_v = shio_pins[i];
      if (en_idx  == CIW'(i)) she_v = shio_pins[i];
    end
    for (int i = 0; i < N_GEN; i++)
      if (en_idx == CIW'(i)) glb_v = gclken[i];
  end

  assign gate = (clk_ded ? ded_v : shc_v) ^ clk_inv;
  assign en   = (en_glb  ? glb_v : she_v) ^ en_inv;
endmodule

// File: rtl/xpt_store.sv
module xpt_store (
  input  logic clk,
  input  logic rst,
  input  logic latch_mode,
  input  logic gate,
  input  logic en,
  input  logic d,
  output logic q_nxt,
  output logic q
);
  logic gate_prev;

  always_comb begin
    q_nxt = q;
    if (latch_mode) begin
      if (gate) q_nxt = d;
    end else if (gate && !gate_prev && en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q         <= 1'b0;
      gate_prev <= 1'b0;
    end else begin
      q         <= q_nxt;
      gate_prev <= gate;
    end
  end

  // R1
  store_reset_chk: assert property (@(posedge clk) rst |=> !q);

  // R5
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!latch_mode && !(gate && !gate_prev && en)) |=> $stable(q));

  // R7
  latch_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_mode && gate) |=> (q == $past(d)));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_mode && !gate) |=> $stable(q));
endmodule

// File: rtl/xpt_io_cell.sv
module xpt_io_cell
  import xpt_pkg::*;
#(
  parameter int N_SEL  = 4,
  parameter int N_DCLK = 2,
  parameter int N_SHIO = 4,
  parameter int N_GEN  = 2,
  parameter int SIW    = (N_SEL > 1) ? $clog2(N_SEL) : 1,
  parameter int MAXP   = (N_DCLK > N_SHIO) ? ((N_DCLK > N_GEN) ? N_DCLK : N_GEN)
                                           : ((N_SHIO > N_GEN) ? N_SHIO : N_GEN),
  parameter int CIW    = (MAXP > 1) ? $clog2(MAXP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        m_in,
  input  logic [N_SEL-1:0]  sel_lines,
  input  logic              pad_in,
  input  logic [N_DCLK-1:0] dclk_pins,
  input  logic [N_SHIO-1:0] shio_pins,
  input  logic [N_GEN-1:0]  gclken,
  input  logic [SIW-1:0]    cfg_s1_idx,
  input  logic [SIW-1:0]    cfg_s0_idx,
  input  logic              cfg_path,
  input  logic              cfg_latch,
  input  logic              cfg_bypass,
  input  logic              cfg_clk_ded,
  input  logic [CIW-1:0]    cfg_clk_idx,
  input  logic              cfg_clk_inv,
  input  logic              cfg_en_glb,
  input  logic [CIW-1:0]    cfg_en_idx,
  input  logic              cfg_en_inv,
  input  logic              cfg_out_inv,
  output logic              pad_out,
  output logic              route_out
);
  path_e      path;
  logic [1:0] mux_code;
  logic       mux_y, gate, en, d, q_nxt, q;
  logic       pad_nxt, route_nxt;

  assign path = path_e'(cfg_path);

  xpt_sel_mux #(.N_SEL(N_SEL), .SIW(SIW)) u_mux (
    .sel_lines(sel_lines), .s1_idx(cfg_s1_idx), .s0_idx(cfg_s0_idx),
    .m_in(m_in), .code(mux_code), .y(mux_y)
  );

  xpt_ctl_src #(.N_DCLK(N_DCLK), .N_SHIO(N_SHIO), .N_GEN(N_GEN), .CIW(CIW)) u_src (
    .dclk_pins(dclk_pins), .shio_pins(shio_pins), .gclken(gclken),
    .clk_ded(cfg_clk_ded), .clk_idx(cfg_clk_idx), .clk_inv(cfg_clk_inv),
    .en_glb(cfg_en_glb), .en_idx(cfg_en_idx), .en_inv(cfg_en_inv),
    .gate(gate), .en(en)
  );

  assign d = (path == PATH_IN) ? pad_in : mux_y;

  xpt_store u_store (
    .clk(clk), .rst(rst), .latch_mode(cfg_latch), .gate(gate), .en(en),
    .d(d), .q_nxt(q_nxt), .q(q)
  );

  always_comb begin
    pad_nxt   = mux_y;
    route_nxt = pad_in;
    if (!cfg_bypass) begin
      if (path == PATH_OUT) pad_nxt   = q_nxt;
      else                  route_nxt = q_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out   <= 1'b0;
      route_out <= 1'b0;
    end else begin
      pad_out   <= pad_nxt ^ cfg_out_inv;
      route_out <= route_nxt;
    end
  end

  // R1
  out_reset_chk: assert property (@(posedge clk) rst |=> (!pad_out && !route_out));

  // R10
  bypass_pad_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_bypass |=> (pad_out == $past(mux_y ^ cfg_out_inv)));

  // R10
  bypass_route_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_bypass |=> (route_out == $past(pad_in)));

  // R9
  inpath_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_path && !cfg_bypass) |=> (pad_out == $past(mux_y ^ cfg_out_inv)));

  // R8
  outpath_route_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_path && !cfg_bypass) |=> (route_out == $past(pad_in)));

  // R8
  outpath_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_path && !cfg_bypass) |=> (pad_out == (q ^ $past(cfg_out_inv))));

  // R9
  inpath_route_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_path && !cfg_bypass) |=> (route_out == q));
endmodule

// File: tb/tb_xpt_io_cell.sv
module tb_xpt_io_cell;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] m_in;
  logic [3:0] sel_lines;
  logic       pad_in;
  logic [1:0] dclk_pins;
  logic [3:0] shio_pins;
  logic [1:0] gclken;
  logic [1:0] cfg_s1_idx, cfg_s0_idx;
  logic       cfg_path, cfg_latch, cfg_bypass, cfg_clk_ded, cfg_clk_inv;
  logic [1:0] cfg_clk_idx, cfg_en_idx;
  logic       cfg_en_glb, cfg_en_inv, cfg_out_inv;
  logic       pad_out, route_out;

  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  xpt_io_cell dut (
    .clk(clk), .rst(rst), .m_in(m_in), .sel_lines(sel_lines), .pad_in(pad_in),
    .dclk_pins(dclk_pins), .shio_pins(shio_pins), .gclken(gclken),
    .cfg_s1_idx(cfg_s1_idx), .cfg_s0_idx(cfg_s0_idx), .cfg_path(cfg_path),
    .cfg_latch(cfg_latch), .cfg_bypass(cfg_bypass), .cfg_clk_ded(cfg_clk_ded),
    .cfg_clk_idx(cfg_clk_idx), .cfg_clk_inv(cfg_clk_inv), .cfg_en_glb(cfg_en_glb),
    .cfg_en_idx(cfg_en_idx), .cfg_en_inv(cfg_en_inv), .cfg_out_inv(cfg_out_inv),
    .pad_out(pad_out), .route_out(route_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic defaults();
    m_in = 4'b0; sel_lines = 4'b0; pad_in = 1'b0;
    dclk_pins = 2'b0; shio_pins = 4'b0; gclken = 2'b01;
    cfg_s1_idx = 2'd1; cfg_s0_idx = 2'd0;
    cfg_path = 1'b0; cfg_latch = 1'b0; cfg_bypass = 1'b1;
    cfg_clk_ded = 1'b1; cfg_clk_idx = 2'd0; cfg_clk_inv = 1'b0;
    cfg_en_glb = 1'b1; cfg_en_idx = 2'd0; cfg_en_inv = 1'b0; cfg_out_inv = 1'b0;
  endtask

  task automatic t_reset();
    defaults();
    m_in = 4'b1111; pad_in = 1'b1; cfg_out_inv = 1'b1;
    rst = 1'b1;
    tick(); tick();
    chk("R1 pad_out in reset", pad_out, 1'b0);
    chk("R1 route_out in reset", route_out, 1'b0);
    rst = 1'b0;
    defaults();
    tick();
  endtask

  task automatic t_decode();
    logic [3:0] pats [2];
    pats[0] = 4'b0110;
    pats[1] = 4'b1001;
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 4; c++) begin
        m_in = pats[p];
        sel_lines = {2'b00, 2'(c)};
        tick();
        chk("R2 mux decode", pad_out, pats[p][c]);
      end
    end
  endtask

  task automatic t_remap();
    m_in = 4'b0010;
    sel_lines = 4'b0100;
    tick();
    chk("R3 default map gives code 00", pad_out, 1'b0);
    cfg_s1_idx = 2'd3; cfg_s0_idx = 2'd2;
    tick();
    chk("R3 remapped lines give code 01", pad_out, 1'b1);
    cfg_s1_idx = 2'd1; cfg_s0_idx = 2'd0; sel_lines = 4'b0;
  endtask

  task automatic t_invert();
    m_in = 4'b0001; pad_in = 1'b1; cfg_out_inv = 1'b1;
    tick();
    chk("R4 pad_out inverted", pad_out, 1'b0);
    chk("R4 R10 route_out not inverted", route_out, 1'b1);
    pad_in = 1'b0;
    tick();
    chk("R10 bypass route follows pad_in", route_out, 1'b0);
    cfg_out_inv = 1'b0;
  endtask

  task automatic t_register();
    cfg_bypass = 1'b0; m_in = 4'b1010; sel_lines = 4'b0001; dclk_pins = 2'b00;
    tick();
    chk("R8 store empty before edge", pad_out, 1'b0);
    dclk_pins = 2'b01;
    tick();
    chk("R5 R8 capture on rising gate", pad_out, 1'b1);
    m_in = 4'b0000;
    tick();
    chk("R5 hold while gate stays high", pad_out, 1'b1);
    dclk_pins = 2'b00;
    tick();
    chk("R5 hold on falling gate", pad_out, 1'b1);
    gclken = 2'b00; dclk_pins = 2'b01;
    tick();
    chk("R5 no capture with enable low", pad_out, 1'b1);
    dclk_pins = 2'b00; cfg_en_inv = 1'b1;
    tick();
    dclk_pins = 2'b01;
    tick();
    chk("R5 inverted enable allows capture", pad_out, 1'b0);
    cfg_en_inv = 1'b0; gclken = 2'b01; dclk_pins = 2'b00;
    tick();
  endtask

  task automatic t_clock_src();
    cfg_clk_ded = 1'b0; cfg_clk_idx = 2'd2; cfg_clk_inv = 1'b1;
    shio_pins = 4'b0100; m_in = 4'b1111;
    tick();
    chk("R6 shared pin high is gate low", pad_out, 1'b0);
    shio_pins = 4'b0000;
    tick();
    chk("R6 R5 falling pin captures when inverted", pad_out, 1'b1);
    m_in = 4'b0000;
    tick();
    shio_pins = 4'b0100;
    tick();
    chk("R6 rising pin ignored when inverted", pad_out, 1'b1);
    cfg_clk_ded = 1'b1; cfg_clk_idx = 2'd3; cfg_clk_inv = 1'b0; shio_pins = 4'b0;
    for (int k = 0; k < 3; k++) begin
      dclk_pins = 2'b11;
      tick();
      dclk_pins = 2'b00;
      tick();
    end
    chk("R6 out-of-range clock index reads 0", pad_out, 1'b1);
    cfg_clk_idx = 2'd0;
    tick();
  endtask

  task automatic t_latch();
    cfg_latch = 1'b1; gclken = 2'b00; dclk_pins = 2'b01; m_in = 4'b1111;
    tick();
    chk("R7 latch transparent, enable ignored", pad_out, 1'b1);
    m_in = 4'b0000;
    tick();
    chk("R7 latch follows data", pad_out, 1'b0);
    dclk_pins = 2'b00; m_in = 4'b1111;
    tick();
    chk("R7 latch holds with gate low", pad_out, 1'b0);
    cfg_latch = 1'b0; gclken = 2'b01;
    tick();
  endtask

  task automatic t_inpath();
    cfg_path = 1'b1; pad_in = 1'b1; m_in = 4'b0001; sel_lines = 4'b0000;
    tick();
    chk("R9 route_out empty before edge", route_out, 1'b0);
    chk("R9 pad_out carries mux", pad_out, 1'b1);
    dclk_pins = 2'b01;
    tick();
    chk("R9 route_out captures pad_in", route_out, 1'b1);
    pad_in = 1'b0; m_in = 4'b0000;
    tick();
    chk("R9 route_out holds", route_out, 1'b1);
    chk("R9 pad_out follows mux", pad_out, 1'b0);
    cfg_bypass = 1'b1;
    tick();
    chk("R10 bypass in input path", route_out, 1'b0);
    cfg_bypass = 1'b0;
    tick();
    chk("R9 stored value still held", route_out, 1'b1);
  endtask

  task automatic t_mid_reset();
    rst = 1'b1;
    tick();
    chk("R1 route_out cleared", route_out, 1'b0);
    rst = 1'b0; dclk_pins = 2'b00; cfg_path = 1'b0; m_in = 4'b1111;
    tick();
    chk("R1 store cleared, no edge", pad_out, 1'b0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    defaults();
    t_reset();
    t_decode();
    t_remap();
    t_invert();
    t_register();
    t_clock_src();
    t_latch();
    t_inpath();
    t_mid_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule